// File: doc/BRIEF.md
# Sweep Holdoff Timer

This block produces the holdoff interval that follows a sweep. When the chosen sweep finishes, the block raises its holdoff output. In the same cycle it sends a one-cycle reset strobe to an external holdoff oscillator, so the oscillator begins from a known phase. It then counts the rising edges of that oscillator. The holdoff output falls when the count reaches a programmed divide ratio. The pulse width is therefore the divide ratio times the oscillator period, plus a few system-clock cycles of synchronizer latency.

A select input decides whether the end of the first sweep or the end of the second sweep starts an interval. Software-side logic writes the divide ratio through a write strobe. A value written while an interval is running takes effect only when the next interval starts. The count is held in `CNT_W` bits. The default of 24 bits reaches beyond half a second even with a fast oscillator.

Top module: `holdoff_timer`

## Requirements
- R1: A low-to-high change on the selected end-of-sweep input, seen at a clock edge while the block is idle, sets `holdoff` high from the following cycle.
- R2: `src_b_sel` = 0 selects `a_sweep_end` and `src_b_sel` = 1 selects `b_sweep_end`. Edges on the input that is not selected start nothing.
- R3: `holdoff` falls after the N-th counted rising edge of the oscillator, where N is the divide ratio latched when the interval started. The width therefore lies between (2N-1)·H+1 and (2N-1)·H+6 cycles for an oscillator with a half period of H cycles that starts low after a reset.
- R4: `osc_in` is sampled through two flip-flops before its rising edges are detected. Any edge already in flight when an interval starts is discarded.
- R5: `osc_reset` is high for exactly one cycle, which is the first cycle in which `holdoff` is high.
- R6: An end-of-sweep edge that arrives while `holdoff` is high is ignored and neither restarts nor extends the interval.
- R7: A ratio written with `ratio_we` is stored at once, but it governs only intervals that start after the write.
- R8: A divide ratio of zero gives the same interval as a ratio of one.
- R9: After reset, `holdoff` and `osc_reset` are low and the stored ratio is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_in | input | 1 | External holdoff oscillator, asynchronous |
| a_sweep_end | input | 1 | End-of-sweep level from the first sweep |
| b_sweep_end | input | 1 | End-of-sweep level from the second sweep |
| src_b_sel | input | 1 | 0: first sweep starts holdoff; 1: second sweep |
| ratio_we | input | 1 | Write strobe for the divide ratio |
| ratio_din | input | CNT_W | Divide ratio to store |
| holdoff | output | 1 | Holdoff pulse |
| osc_reset | output | 1 | One-cycle reset strobe to the oscillator |

## Verification
The assertions assume that the oscillator is held low while `osc_reset` is high and that it responds within the same system-clock cycle. They also assume that the oscillator has a period of at least four system clocks, so the synchronizer never merges two edges. The bench models the oscillator to meet both conditions. It forces the oscillator low on every clock in which it sees the strobe, then restarts it with a fixed half period of three cycles. Sweep-end and ratio inputs change only between clock edges.

// File: rtl/holdoff_pkg.sv
// Package: shared state encoding for the holdoff timer.
// Assumes: nothing; it holds only type definitions.
package holdoff_pkg;
    typedef enum logic [1:0] {
        HS_IDLE = 2'd0,
        HS_ARM  = 2'd1,
        HS_RUN  = 2'd2
    } hold_state_t;
endpackage

// File: rtl/holdoff_osc_sync.sv
// Module: synchronizer for the holdoff oscillator, plus rising-edge detection.
// Assumes: the oscillator period is at least four clock cycles. The clear
// input empties the pipeline so that no edge from before an interval is counted.
module holdoff_osc_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_raw,
    input  logic flush,
    output logic osc_rise
);
    logic meta_q;
    logic sync_q;
    logic last_q;

    // Purpose: two-flop synchronizer, then a delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            last_q <= 1'b0;
        end else begin
            meta_q <= osc_raw;
            sync_q <= meta_q;
            last_q <= sync_q;
        end
    end

    // Purpose: a rising edge is a high synchronized sample after a low one.
    always_comb osc_rise = sync_q & ~last_q;
endmodule

// File: rtl/holdoff_start_sel.sv
// Module: detects the rising edge of each end-of-sweep input and picks one.
// Assumes: the sweep-end inputs are synchronous to clk. A start is blocked
// while the timer is busy.
module holdoff_start_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic a_end,
    input  logic b_end,
    input  logic use_b,
    input  logic busy,
    output logic start
);
    logic a_prev_q;
    logic b_prev_q;
    logic a_edge;
    logic b_edge;

    // Purpose: remember the previous level of both sweep-end inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_prev_q <= 1'b0;
            b_prev_q <= 1'b0;
        end else begin
            a_prev_q <= a_end;
            b_prev_q <= b_end;
        end
    end

    // Purpose: find the edges, take the selected one, and block it while busy.
    always_comb begin
        a_edge = a_end & ~a_prev_q;
        b_edge = b_end & ~b_prev_q;
        start  = (use_b ? b_edge : a_edge) & ~busy;
    end
endmodule

// File: rtl/holdoff_div_counter.sv
// Module: stores the divide ratio and runs the interval state machine.
// Assumes: start is raised only while idle. osc_rise is already synchronous.
module holdoff_div_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             osc_rise,
    input  logic             ratio_we,
    input  logic [CNT_W-1:0] ratio_din,
    output logic             busy,
    output logic             strobe,
    output logic [CNT_W-1:0] cur_cnt,
    output logic [CNT_W-1:0] cur_ratio
);
    import holdoff_pkg::*;

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    hold_state_t      state_q;
    logic [CNT_W-1:0] pend_q;
    logic [CNT_W-1:0] run_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;
    logic             last_edge;

    // Purpose: hold the most recently written ratio until an interval takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else if (ratio_we) begin
            pend_q <= ratio_din;
        end
    end

    // Purpose: find the oscillator edge that completes the interval.
    always_comb begin
        cnt_inc   = cnt_q + ONE;
        last_edge = osc_rise && (cnt_inc == run_q);
    end

    // Purpose: run idle -> arm (strobe) -> count, and latch the ratio at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HS_IDLE;
            run_q   <= ONE;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                HS_IDLE: begin
                    if (start) begin
                        state_q <= HS_ARM;
                        run_q   <= (pend_q == '0) ? ONE : pend_q;
                        cnt_q   <= '0;
                    end
                end
                HS_ARM: begin
                    state_q <= HS_RUN;
                end
                HS_RUN: begin
                    if (last_edge) begin
                        state_q <= HS_IDLE;
                        cnt_q   <= '0;
                    end else if (osc_rise) begin
                        cnt_q <= cnt_inc;
                    end
                end
                default: state_q <= HS_IDLE;
            endcase
        end
    end

    // Purpose: decode the outputs from the state register.
    always_comb begin
        busy      = (state_q != HS_IDLE);
        strobe    = (state_q == HS_ARM);
        cur_cnt   = cnt_q;
        cur_ratio = run_q;
    end
endmodule

// File: rtl/holdoff_timer.sv
// Module: top of the sweep holdoff timer.
// Assumes: a synchronous active-low reset. The oscillator goes low while
// osc_reset is high.
module holdoff_timer #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_in,
    input  logic             a_sweep_end,
    input  logic             b_sweep_end,
    input  logic             src_b_sel,
    input  logic             ratio_we,
    input  logic [CNT_W-1:0] ratio_din,
    output logic             holdoff,
    output logic             osc_reset
);
    logic             start;
    logic             osc_rise;
    logic             busy;
    logic             strobe;
    logic [CNT_W-1:0] cur_cnt;
    logic [CNT_W-1:0] cur_ratio;

    holdoff_start_sel u_sel (
        .clk   (clk),
        .rst_n (rst_n),
        .a_end (a_sweep_end),
        .b_end (b_sweep_end),
        .use_b (src_b_sel),
        .busy  (busy),
        .start (start)
    );

    holdoff_osc_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_raw  (osc_in),
        .flush    (start),
        .osc_rise (osc_rise)
    );

    holdoff_div_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .osc_rise  (osc_rise),
        .ratio_we  (ratio_we),
        .ratio_din (ratio_din),
        .busy      (busy),
        .strobe    (strobe),
        .cur_cnt   (cur_cnt),
        .cur_ratio (cur_ratio)
    );

    // Purpose: drive the ports from the counter's decoded state.
    always_comb begin
        holdoff   = busy;
        osc_reset = strobe;
    end
endmodule

// File: rtl/holdoff_timer_chk.sv
// Module: timing properties of the holdoff timer, attached to it with bind.
// Assumes: the oscillator behaves as stated in the brief.
module holdoff_timer_chk #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             holdoff,
    input logic             osc_reset,
    input logic             osc_rise,
    input logic [CNT_W-1:0] cur_cnt,
    input logic [CNT_W-1:0] cur_ratio
);
    // R5: the strobe lasts one cycle
    p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        osc_reset |=> !osc_reset);
    // R5: the strobe occurs only inside holdoff
    p_strobe_in_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        osc_reset |-> holdoff);
    // R1: every interval opens with the strobe
    p_open_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(holdoff) |-> osc_reset);
    // R3: the count stays below the ratio
    p_cnt_below_r3: assert property (@(posedge clk) disable iff (!rst_n)
        holdoff |-> (cur_cnt < cur_ratio));
    // R3: the interval closes only on an oscillator edge
    p_close_on_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(holdoff) |-> $past(osc_rise));
    // R7: the ratio in use is frozen while an interval runs
    p_ratio_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (holdoff && !osc_reset) |-> $stable(cur_ratio));
    // R8: the ratio in use is never zero
    p_ratio_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        holdoff |-> (cur_ratio != '0));
endmodule

bind holdoff_timer holdoff_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .holdoff   (holdoff),
    .osc_reset (osc_reset),
    .osc_rise  (osc_rise),
    .cur_cnt   (cur_cnt),
    .cur_ratio (cur_ratio)
);

// File: tb/holdoff_timer_test.sv
module holdoff_timer_test;
    localparam int CW = 24;
    localparam int H  = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          osc_in = 1'b0;
    logic          a_end = 1'b0;
    logic          b_end = 1'b0;
    logic          sel_b = 1'b0;
    logic          we = 1'b0;
    logic [CW-1:0] din = '0;
    logic          holdoff;
    logic          osc_reset;

    int    errors = 0;
    int    checks = 0;
    int    cycles = 0;
    string cur_req = "R9";

    holdoff_timer #(.CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .osc_in(osc_in),
        .a_sweep_end(a_end), .b_sweep_end(b_end), .src_b_sel(sel_b),
        .ratio_we(we), .ratio_din(din),
        .holdoff(holdoff), .osc_reset(osc_reset)
    );

    always #2 clk = ~clk;

    // Oscillator model: forced low during the strobe, otherwise half period H.
    int ph = 0;
    always @(negedge clk) begin
        if (osc_reset) begin
            ph = 0;
            osc_in = 1'b0;
        end else begin
            ph = ph + 1;
            osc_in = ((ph / H) % 2) == 1;
        end
    end

    // Behavioural reference model, updated on each rising edge.
    int m_phase = 0;
    int m_cnt = 0;
    int m_ratio = 1;
    int m_pend = 0;
    bit m_pa = 0, m_pb = 0;
    bit q[$] = '{0, 0, 0};

    always @(posedge clk) begin
        bit rise, ev, starting;
        cycles++;
        if (!rst_n) begin
            m_phase = 0; m_cnt = 0; m_ratio = 1; m_pend = 0;
            m_pa = 0; m_pb = 0; q = '{0, 0, 0};
        end else begin
            rise = (q[1] == 1'b1) && (q[0] == 1'b0);
            ev = sel_b ? (b_end && !m_pb) : (a_end && !m_pa);
            starting = 0;
            case (m_phase)
                0: if (ev) begin
                    m_phase = 1; m_cnt = 0;
                    m_ratio = (m_pend == 0) ? 1 : m_pend;
                    starting = 1;
                end
                1: m_phase = 2;
                default: if (rise) begin
                    m_cnt++;
                    if (m_cnt == m_ratio) m_phase = 0;
                end
            endcase
            if (we) m_pend = int'(din);
            m_pa = a_end; m_pb = b_end;
            q.push_back(osc_in);
            void'(q.pop_front());
            if (starting) q = '{0, 0, 0};
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // Compare the design with the model on every falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            check({cur_req, " holdoff"}, int'(holdoff), int'(m_phase != 0));
            check({cur_req, " osc_reset"}, int'(osc_reset), int'(m_phase == 1));
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=100000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic write_ratio(input int r);
        @(negedge clk); we = 1'b1; din = CW'(r);
        @(negedge clk); we = 1'b0;
    endtask

    task automatic pulse(input bit on_b);
        @(negedge clk);
        if (on_b) b_end = 1'b1; else a_end = 1'b1;
        @(negedge clk);
        a_end = 1'b0; b_end = 1'b0;
    endtask

    task automatic measure(output int w);
        w = 0;
        while (holdoff && w < 5000) begin
            w++;
            @(negedge clk);
        end
    endtask

    task automatic check_width(input string req, input int w, input int n);
        int lo, hi;
        lo = (2 * n - 1) * H + 1;
        hi = (2 * n - 1) * H + 6;
        checks++;
        if (w < lo || w > hi) begin
            errors++;
            $display("FAIL %s width: actual=%0d expected=%0d..%0d", req, w, lo, hi);
        end
    endtask

    initial begin
        int w, w1;
        repeat (3) @(negedge clk);
        cur_req = "R9";
        check("R9 reset holdoff", int'(holdoff), 0);
        check("R9 reset osc_reset", int'(osc_reset), 0);
        @(negedge clk); rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R8 / R9: the stored ratio is zero after reset, so the interval matches ratio one.
        cur_req = "R8";
        pulse(1'b0);
        check("R1 holdoff start", int'(holdoff), 1);
        check("R5 strobe first cycle", int'(osc_reset), 1);
        measure(w);
        check_width("R8", w, 1);
        w1 = w;
        write_ratio(1);
        repeat (5) @(negedge clk);
        pulse(1'b0);
        measure(w);
        check("R8 zero equals one", w, w1);

        // R3: a larger ratio with source A.
        cur_req = "R3";
        write_ratio(4);
        repeat (3) @(negedge clk);
        pulse(1'b0);
        measure(w);
        check_width("R3", w, 4);

        // R2: source B selected, so an edge on A starts nothing.
        cur_req = "R2";
        sel_b = 1'b1;
        repeat (2) @(negedge clk);
        pulse(1'b0);
        repeat (3) @(negedge clk);
        check("R2 unselected ignored", int'(holdoff), 0);
        pulse(1'b1);
        check("R2 selected B starts", int'(holdoff), 1);
        measure(w);
        check_width("R2", w, 4);

        // R6: an edge during holdoff neither extends nor restarts the interval.
        cur_req = "R6";
        write_ratio(3);
        repeat (2) @(negedge clk);
        pulse(1'b1);
        repeat (4) @(negedge clk);
        pulse(1'b1);
        measure(w);
        check_width("R6", w + 6, 3);
        repeat (3) @(negedge clk);
        check("R6 no restart", int'(holdoff), 0);

        // R7: a write during holdoff applies only to the next interval.
        cur_req = "R7";
        write_ratio(2);
        repeat (2) @(negedge clk);
        pulse(1'b1);
        write_ratio(5);
        measure(w);
        check_width("R7 current", w + 2, 2);
        repeat (2) @(negedge clk);
        pulse(1'b1);
        measure(w);
        check_width("R7 next", w, 5);

        // R4 / R1: restart straight after an interval ends, with the oscillator mid-phase.
        cur_req = "R4";
        write_ratio(2);
        pulse(1'b1);
        measure(w);
        check_width("R4", w, 2);
        pulse(1'b1);
        measure(w);
        check_width("R4 back-to-back", w, 2);

        repeat (10) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule